// File: doc/BRIEF.md
# Rendering Command Queue with Level Interrupts

This block sits between a processor's 16-bit register bus and a rendering engine that consumes 32-bit commands. Software builds each command in two half-word holding registers. A write that carries the upper byte lane of the high half-word pushes the assembled command into a 16-entry first-in first-out store. The engine drains the store over a valid/ready handshake.

The block presents its occupancy, full and empty status, and a watermark status as live outputs. Three sticky interrupt flags record the queue becoming empty, becoming full, and draining through a programmable level. Software can mask each flag and can clear it by writing zero. The interrupt line is the OR of the unmasked flags.

Register map (3-bit address, byte lanes `reg_be_i[1]` upper and `reg_be_i[0]` lower): 0 = command low half, 1 = command high half, 2 = watermark level in bits [4:0], 3 = interrupt enables in bits [2:0], 4 = interrupt flags in bits [2:0]. Flag and enable bit positions are: bit 0 empty, bit 1 full, bit 2 watermark. Writes to addresses 2, 3 and 4 take effect only when the lower byte lane is set.

Top module: `cmd_queue_ctrl`

## Requirements
- R1: A write to the low half-word (address 0) updates the low holding register, per byte lane, and never pushes a command.
- R2: A write to the high half-word (address 1) with `reg_be_i[1]` set pushes {high, low} with the written lanes merged in. A write with only `reg_be_i[0]` set updates high bits [7:0] and does not push.
- R3: Commands leave in push order. `count_o` is the occupancy, from 0 to 16, and it changes at the clock edge of the push or pop.
- R4: A push is accepted only when the occupancy before the edge is below 16. A push at 16 is dropped, even when a pop happens in the same cycle.
- R5: `cmd_valid_o` is high when the occupancy is nonzero. A pop happens when valid and `cmd_ready_i` are both high. A pop and an accepted push in the same cycle leave the occupancy unchanged.
- R6: `full_o` is high exactly when the occupancy is 16. `empty_o` is high exactly when the occupancy is 0.
- R7: `wm_below_o` is high exactly when the occupancy is below the watermark level. It is therefore low when the level is 0.
- R8: With a watermark level N from 1 to 16, flag bit 2 sets one cycle after the occupancy changes from N to N-1. It never sets when the level is 0.
- R9: Flag bit 0 sets one cycle after the occupancy becomes 0 from nonzero. Flag bit 1 sets one cycle after the occupancy reaches 16. Both flags stay set until cleared.
- R10: A flag write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A set in the same cycle wins over a clear.
- R11: `irq_o` is the OR of the flags ANDed with their enable bits, in the same cycle as the flags.
- R12: After reset the queue is empty, and all flags, enables, the watermark level and the holding registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_be_i | input | 2 | Byte lane enables |
| cmd_valid_o | output | 1 | Head command available |
| cmd_ready_i | input | 1 | Consumer takes head command |
| cmd_data_o | output | 32 | Head command |
| count_o | output | 5 | Occupancy |
| full_o | output | 1 | Queue holds 16 commands |
| empty_o | output | 1 | Queue holds no command |
| wm_below_o | output | 1 | Occupancy below watermark level |
| irq_flags_o | output | 3 | Sticky flags: empty, full, watermark |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A register write or a pop at clock edge k changes the occupancy, the status outputs and the head command from edge k on. The sticky flags, and `irq_o` with them, change one edge later, at k+1, because they compare the current occupancy with the value one cycle earlier. The bench drives every input on the falling edge. It advances its queue model on the rising edge using the same delays, and it compares every output on the next falling edge, so each result is sampled half a cycle after the edge that produced it. Directed checks placed after a write task returns rely on the same count of edges.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CMD_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] A_WMARK    = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQ_EN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQ_FLAG = 3'd4;
  localparam int NFLAG   = 3;
  localparam int F_EMPTY = 0;
  localparam int F_FULL  = 1;
  localparam int F_WMARK = 2;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [BE_W-1:0]     be_i,
  output logic                push_o,
  output logic [2*DATA_W-1:0] push_data_o,
  output logic [CNT_W-1:0]    wmark_o,
  output logic [NFLAG-1:0]    irq_en_o,
  output logic                flag_wr_o,
  output logic [NFLAG-1:0]    flag_wdata_o
);
  logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic sel_lo, sel_hi;

  assign sel_lo = wr_i && (addr_i == A_CMD_LO);
  assign sel_hi = wr_i && (addr_i == A_CMD_HI);

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lo_d[b*8 +: 8] = (sel_lo && be_i[b]) ? wdata_i[b*8 +: 8] : lo_q[b*8 +: 8];
    assign hi_d[b*8 +: 8] = (sel_hi && be_i[b]) ? wdata_i[b*8 +: 8] : hi_q[b*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      wmark_o  <= '0;
      irq_en_o <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      if (wr_i && addr_i == A_WMARK && be_i[0])  wmark_o  <= wdata_i[CNT_W-1:0];
      if (wr_i && addr_i == A_IRQ_EN && be_i[0]) irq_en_o <= wdata_i[NFLAG-1:0];
    end
  end

  // upper lane of the high half is the push trigger
  assign push_o       = sel_hi && be_i[BE_W-1];
  assign push_data_o  = {hi_d, lo_q};
  assign flag_wr_o    = wr_i && (addr_i == A_IRQ_FLAG) && be_i[0];
  assign flag_wdata_o = wdata_i[NFLAG-1:0];

  a_r1_lo_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CMD_LO) |-> !push_o);
  a_r2_lowbyte_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CMD_HI && !be_i[BE_W-1]) |-> !push_o);
endmodule

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DEPTH = 16,
  parameter int CMD_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [CMD_W-1:0] push_data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [CMD_W-1:0] data_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST     = PTR_W'(DEPTH - 1);

  logic [CMD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic acc_push, do_pop;

  assign valid_o  = (count_o != '0);
  assign do_pop   = valid_o && ready_i;
  assign acc_push = push_i && (count_o != FULL_CNT); // full drops even with a pop
  assign data_o   = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (acc_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (acc_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({acc_push, do_pop})
        2'b10:   count_o <= count_o + CNT_W'(1);
        2'b01:   count_o <= count_o - CNT_W'(1);
        default: count_o <= count_o;
      endcase
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  a_r4_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == FULL_CNT && push_i && !ready_i) |=> count_o == FULL_CNT);
  a_r5_push_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && ready_i && count_o != '0 && count_o != FULL_CNT) |=> $stable(count_o));
endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] wmark_i,
  input  logic [NFLAG-1:0] en_i,
  input  logic             flag_wr_i,
  input  logic [NFLAG-1:0] flag_wdata_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] prev_cnt;
  logic [NFLAG-1:0] set, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_cnt <= '0;
    else         prev_cnt <= count_i;
  end

  // condition edges from the occupancy one cycle apart
  assign set[F_EMPTY] = (count_i == '0) && (prev_cnt != '0);
  assign set[F_FULL]  = (count_i == FULL_CNT) && (prev_cnt != FULL_CNT);
  assign set[F_WMARK] = (wmark_i != '0) && (prev_cnt == wmark_i) &&
                        (count_i == wmark_i - CNT_W'(1));
  assign clr = flag_wr_i ? ~flag_wdata_i : '0;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[i] <= 1'b0;
      else         flags_o[i] <= set[i] | (flags_o[i] & ~clr[i]);
    end

    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[i] |=> flags_o[i]);
    a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[i] && !clr[i]) |=> flags_o[i]);
  end

  assign irq_o = |(flags_o & en_i);

  a_r8_wm_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_WMARK]) |-> ($past(count_i) + CNT_W'(1) == $past(wmark_i)));
endmodule

// File: rtl/cmd_queue_ctrl.sv
module cmd_queue_ctrl
  import cmdq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int CMD_W = 2 * DATA_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [BE_W-1:0]   reg_be_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CMD_W-1:0]  cmd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              wm_below_o,
  output logic [NFLAG-1:0]  irq_flags_o,
  output logic              irq_o
);
  logic             push, flag_wr;
  logic [CMD_W-1:0] push_data;
  logic [CNT_W-1:0] wmark;
  logic [NFLAG-1:0] irq_en, flag_wdata;

  cmdq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .be_i(reg_be_i),
    .push_o(push), .push_data_o(push_data), .wmark_o(wmark), .irq_en_o(irq_en),
    .flag_wr_o(flag_wr), .flag_wdata_o(flag_wdata)
  );

  cmdq_fifo #(.DEPTH(DEPTH), .CMD_W(CMD_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(push_data), .ready_i(cmd_ready_i),
    .valid_o(cmd_valid_o), .data_o(cmd_data_o), .count_o(count_o)
  );

  cmdq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk_i, .rst_ni,
    .count_i(count_o), .wmark_i(wmark), .en_i(irq_en),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .flags_o(irq_flags_o), .irq_o(irq_o)
  );

  assign full_o     = (count_o == CNT_W'(DEPTH));
  assign empty_o    = (count_o == '0);
  assign wm_below_o = (count_o < wmark);
endmodule

// File: tb/cmd_queue_ctrl_test.sv
module cmd_queue_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [1:0]  reg_be = 0;
  logic        ready = 0;
  logic        cmd_valid, full, empty, wm_below, irq;
  logic [31:0] cmd_data;
  logic [4:0]  count;
  logic [2:0]  flags;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  cmd_queue_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_be_i(reg_be), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(ready), .cmd_data_o(cmd_data), .count_o(count), .full_o(full),
    .empty_o(empty), .wm_below_o(wm_below), .irq_flags_o(flags), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] q[$];
  logic [15:0] m_lo, m_hi;
  logic [4:0]  m_wm;
  logic [2:0]  m_en, m_flags;
  int          m_prev;

  always @(posedge clk) begin : model
    int sz;
    logic [2:0] set, clr;
    logic [15:0] nhi;
    if (!rst_n) begin
      q.delete(); m_lo = 0; m_hi = 0; m_wm = 0; m_en = 0; m_flags = 0; m_prev = 0;
    end else begin
      sz = q.size();
      set[0] = (sz == 0) && (m_prev != 0);
      set[1] = (sz == 16) && (m_prev != 16);
      set[2] = (m_wm != 0) && (m_prev == int'(m_wm)) && (sz == int'(m_wm) - 1);
      clr = (reg_wr && reg_addr == 4 && reg_be[0]) ? ~reg_wdata[2:0] : 3'b000;
      m_flags = set | (m_flags & ~clr);
      m_prev = sz;
      nhi = m_hi;
      if (reg_wr && reg_addr == 1) begin
        if (reg_be[0]) nhi[7:0]  = reg_wdata[7:0];
        if (reg_be[1]) nhi[15:8] = reg_wdata[15:8];
      end
      if (sz > 0 && ready) void'(q.pop_front());
      if (reg_wr && reg_addr == 1 && reg_be[1] && sz < 16) q.push_back({nhi, m_lo});
      m_hi = nhi;
      if (reg_wr && reg_addr == 0) begin
        if (reg_be[0]) m_lo[7:0]  = reg_wdata[7:0];
        if (reg_be[1]) m_lo[15:8] = reg_wdata[15:8];
      end
      if (reg_wr && reg_addr == 2 && reg_be[0]) m_wm = reg_wdata[4:0];
      if (reg_wr && reg_addr == 3 && reg_be[0]) m_en = reg_wdata[2:0];
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3 count", int'(count), q.size());
      chk("R6 empty", int'(empty), int'(q.size() == 0));
      chk("R6 full", int'(full), int'(q.size() == 16));
      chk("R7 wm_below", int'(wm_below), int'(q.size() < int'(m_wm)));
      chk("R9 R10 empty/full flags", int'(flags[1:0]), int'(m_flags[1:0]));
      chk("R8 R10 watermark flag", int'(flags[2]), int'(m_flags[2]));
      chk("R11 irq", int'(irq), int'(|(m_flags & m_en)));
      chk("R5 valid", int'(cmd_valid), int'(q.size() > 0));
      if (q.size() > 0) chk("R2 R3 head data", int'(cmd_data), int'(q[0]));
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0; reg_be = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 count", int'(count), 0);
    chk("R12 flags", int'(flags), 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 empty", int'(empty), 1);

    wr(3, 16'h0007, 2'b01);            // all enables
    wr(2, 16'h0004, 2'b01);            // watermark 4
    wr(0, 16'h1111, 2'b11);
    chk("R1 low write no push", int'(count), 0);
    wr(1, 16'hAA22, 2'b01);
    chk("R2 low-lane high write no push", int'(count), 0);
    wr(1, 16'h33BB, 2'b10);
    chk("R2 upper-lane push count", int'(count), 1);
    chk("R2 assembled command", int'(cmd_data), 32'h3322_1111);

    // fill past capacity: R4 drops the extras
    for (int i = 0; i < 20; i++) begin
      wr(0, 16'(i), 2'b11);
      wr(1, 16'(16'hC000 + i), 2'b11);
    end
    chk("R4 capped at 16", int'(count), 16);
    idle(1);
    chk("R9 full flag", int'(flags[1]), 1);
    wr(4, 16'h0007, 2'b01);
    chk("R10 write 1 keeps", int'(flags[1]), 1);
    wr(4, 16'h0000, 2'b01);
    chk("R10 write 0 clears", int'(flags[1]), 0);

    // push while full with a pop in the same cycle: dropped (R4)
    @(negedge clk); ready = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 16'hDEAD; reg_be = 2'b11;
    @(negedge clk); ready = 0; reg_wr = 0; reg_be = 0;
    chk("R4 full push with pop dropped", int'(count), 15);

    // simultaneous push and pop: R5
    @(negedge clk); ready = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 16'hBEEF; reg_be = 2'b11;
    @(negedge clk); ready = 0; reg_wr = 0; reg_be = 0;
    chk("R5 push+pop holds count", int'(count), 15);

    // drain through the watermark (R8), then to empty (R9)
    @(negedge clk); ready = 1;
    while (count > 1) @(negedge clk);
    ready = 0;
    idle(1);
    chk("R8 watermark flag set", int'(flags[2]), 1);
    // pop the last entry while clearing all flags in the cycle the empty flag sets
    ready = 1;
    @(negedge clk); ready = 0;
    reg_wr = 1; reg_addr = 4; reg_wdata = 16'h0000; reg_be = 2'b01;
    @(negedge clk); reg_wr = 0; reg_be = 0;
    chk("R10 set wins over clear", int'(flags[0]), 1);
    chk("R10 other flags cleared", int'(flags[2:1]), 0);

    // watermark 0 disables the event
    wr(4, 16'h0000, 2'b01);
    wr(2, 16'h0000, 2'b01);
    for (int i = 0; i < 6; i++) wr(1, 16'(i), 2'b10);
    @(negedge clk); ready = 1;
    while (count > 0) @(negedge clk);
    ready = 0;
    idle(2);
    chk("R8 level 0 never fires", int'(flags[2]), 0);
    chk("R7 level 0 below low", int'(wm_below), 0);

    // watermark 16: fires on 16 to 15
    wr(4, 16'h0000, 2'b01);
    wr(2, 16'h0010, 2'b01);
    for (int i = 0; i < 16; i++) wr(1, 16'(16'h5000 + i), 2'b11);
    @(negedge clk); ready = 1;
    @(negedge clk); ready = 0;
    idle(1);
    chk("R8 level 16 fires", int'(flags[2]), 1);

    // masked interrupt: R11
    wr(3, 16'h0000, 2'b01);
    chk("R11 masked", int'(irq), 0);

    // mixed random traffic compared cycle by cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ready    = ($urandom % 3) == 0;
      reg_wr   = ($urandom % 2) == 0;
      reg_addr = 3'($urandom % 5);
      reg_wdata = 16'($urandom);
      reg_be   = 2'($urandom);
      if (reg_addr == 2) reg_wdata[4:0] = 5'($urandom % 17);
    end
    @(negedge clk); reg_wr = 0; reg_be = 0; ready = 0;
    idle(3);
    summary();
  end
endmodule